// File: doc/BRIEF.md
# Planar Raster-Op Write Datapath

This block forms the data for one CPU write into a memory split into four bit planes. Each plane holds one bit of every pixel in an 8-pixel byte. The block takes the CPU byte, the four latch bytes left by an earlier read, a 4-bit fill color with a per-plane fill-enable mask, a rotate count, a logic-operation select, a pixel mask and a 2-bit write mode. From these it produces the four plane bytes to store.

Plane gating, the memory and the register port all sit outside the block. The caller holds the configuration steady and pulses a write request. One clock later the block presents the four plane bytes together with a one-cycle write strobe.

Top module: `prw_datapath`

## Requirements
- R1: After reset, all four plane outputs and the write strobe are zero.
- R2: The strobe is high for exactly the one cycle after a cycle with `wr_req` high. The plane outputs are updated in that same cycle and are held at other times.
- R3: The CPU byte is rotated right circularly by `rot_cnt` (0 to 7) positions. A count of 0 leaves it unchanged.
- R4: `op_sel` chooses the operation applied against the latch: 0 passes the source, 1 ANDs it with the latch, 2 ORs it with the latch, 3 XORs it with the latch.
- R5: Per pixel bit i, a pixel-mask bit of 0 writes the latch bit back unchanged. A mask bit of 1 writes the operation result.
- R6: In mode 0 (`wr_mode`=0), plane p takes `fill_color[p]` replicated to 8 bits as its source when `fill_en[p]` is 1. Otherwise it takes the rotated CPU byte.
- R7: In mode 1, each plane output equals its latch. CPU data, operation, mask and fill settings have no effect.
- R8: In mode 2, plane p takes `cpu_data[p]` replicated as its source, whatever `fill_en` holds. The operation and mask then apply as in mode 0.
- R9: In mode 3, plane p takes `fill_color[p]` replicated as its source, whatever `fill_en` holds. The effective mask is the rotated CPU byte AND `pix_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Write request, one cycle per write |
| wr_mode | input | 2 | Write mode 0..3 |
| cpu_data | input | 8 | CPU write byte |
| latch_data | input | 32 | Latches, plane p in bits 8p+7:8p |
| fill_color | input | 4 | Per-plane fill color bit |
| fill_en | input | 4 | Per-plane fill enable (mode 0) |
| rot_cnt | input | 3 | Right-rotate count |
| op_sel | input | 2 | Logic operation select |
| pix_mask | input | 8 | Pixel write mask |
| plane_out | output | 32 | Plane bytes to write, plane p in bits 8p+7:8p |
| wr_stb | output | 1 | Write strobe |

## Verification
The bench uses latch values that differ in every plane. A swapped plane index or a wrong latch source therefore shows as a plane mismatch. It covers rotate counts 0, 1 and 7 with an asymmetric byte, so a left rotate or a shift that drops bits gives a wrong value. In modes 2 and 3 it sets `fill_en` to a value that would change the result if it were wrongly honoured. In mode 1 it drives hostile mask and operation values. It also checks that the mode-3 mask really combines the rotated CPU byte with `pix_mask`; a design that used `pix_mask` alone would write latch-only pixels.

// File: rtl/prw_pkg.sv
package prw_pkg;
   localparam int PLANES = 4;
   localparam int PIXW   = 8;
   localparam int ROTW   = $clog2(PIXW);
   typedef enum logic [1:0] {WM_CPU = 2'd0, WM_LATCH = 2'd1, WM_COLOR = 2'd2, WM_MASKED = 2'd3} wmode_t;
   typedef enum logic [1:0] {OP_PASS = 2'd0, OP_AND = 2'd1, OP_OR = 2'd2, OP_XOR = 2'd3} op_t;
endpackage

// File: rtl/prw_rotator.sv
module prw_rotator #(
   parameter int W  = 8,
   parameter int CW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [CW-1:0] cnt,
   output logic [W-1:0]  dout
);
   logic [2*W-1:0] dbl;
   always_comb begin
      dbl  = {din, din} >> cnt;
      dout = dbl[W-1:0];
   end
endmodule

// File: rtl/prw_plane_alu.sv
module prw_plane_alu #(
   parameter int W = 8
) (
   input  logic [W-1:0] src,
   input  logic [W-1:0] latch,
   input  logic [W-1:0] mask,
   input  logic [1:0]   op,
   output logic [W-1:0] result
);
   import prw_pkg::*;
   logic [W-1:0] fn;
   always_comb begin
      unique case (op_t'(op))
         OP_AND:  fn = src & latch;
         OP_OR:   fn = src | latch;
         OP_XOR:  fn = src ^ latch;
         default: fn = src;
      endcase
      result = (fn & mask) | (latch & ~mask);
   end
endmodule

// File: rtl/prw_datapath.sv
module prw_datapath #(
   parameter int NPLANE = prw_pkg::PLANES,
   parameter int PW     = prw_pkg::PIXW
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_req,
   input  logic [1:0]             wr_mode,
   input  logic [PW-1:0]          cpu_data,
   input  logic [NPLANE*PW-1:0]   latch_data,
   input  logic [NPLANE-1:0]      fill_color,
   input  logic [NPLANE-1:0]      fill_en,
   input  logic [$clog2(PW)-1:0]  rot_cnt,
   input  logic [1:0]             op_sel,
   input  logic [PW-1:0]          pix_mask,
   output logic [NPLANE*PW-1:0]   plane_out,
   output logic                   wr_stb
);
   import prw_pkg::*;
   localparam int CW = $clog2(PW);

   initial begin
      assert (PW >= 2 && (PW & (PW - 1)) == 0) else $error("PW must be a power of two");
      assert (NPLANE >= 1 && NPLANE <= PW) else $error("NPLANE out of range");
   end

   logic [PW-1:0]        rot_data;
   logic [PW-1:0]        eff_mask;
   logic [NPLANE*PW-1:0] next_out;

   prw_rotator #(.W(PW), .CW(CW)) u_rot (.din(cpu_data), .cnt(rot_cnt), .dout(rot_data));

   always_comb begin
      eff_mask = (wmode_t'(wr_mode) == WM_MASKED) ? (rot_data & pix_mask) : pix_mask;
   end

   for (genvar p = 0; p < NPLANE; p++) begin : g_plane
      logic [PW-1:0] src;
      logic [PW-1:0] res;
      logic [PW-1:0] lat;
      assign lat = latch_data[p*PW +: PW];
      always_comb begin
         unique case (wmode_t'(wr_mode))
            WM_CPU:    src = fill_en[p] ? {PW{fill_color[p]}} : rot_data;
            WM_COLOR:  src = {PW{cpu_data[p]}};
            WM_MASKED: src = {PW{fill_color[p]}};
            default:   src = lat;
         endcase
      end
      prw_plane_alu #(.W(PW)) u_alu (
         .src(src), .latch(lat), .mask(eff_mask), .op(op_sel), .result(res));
      assign next_out[p*PW +: PW] = (wmode_t'(wr_mode) == WM_LATCH) ? lat : res;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         plane_out <= '0;
         wr_stb    <= 1'b0;
      end else begin
         wr_stb <= wr_req;
         if (wr_req) plane_out <= next_out;
      end
   end
endmodule

// File: rtl/prw_datapath_chk.sv
module prw_datapath_chk #(
   parameter int NPLANE = 4,
   parameter int PW     = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_req,
   input logic [1:0]           wr_mode,
   input logic [NPLANE*PW-1:0] latch_data,
   input logic [PW-1:0]        pix_mask,
   input logic [NPLANE*PW-1:0] plane_out,
   input logic                 wr_stb
);
   AST_STB_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> wr_stb) else $error("strobe missing"); // R2
   AST_STB_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |=> !wr_stb) else $error("spurious strobe"); // R2
   AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |=> $stable(plane_out)) else $error("output changed"); // R2
   AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_mode == 2'd1) |=> plane_out == $past(latch_data)) else $error("mode 1"); // R7
   AST_MASK_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && pix_mask == '0) |=> plane_out == $past(latch_data)) else $error("mask"); // R5
endmodule

bind prw_datapath prw_datapath_chk #(.NPLANE(NPLANE), .PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_mode(wr_mode),
   .latch_data(latch_data), .pix_mask(pix_mask), .plane_out(plane_out), .wr_stb(wr_stb));

// File: tb/prw_datapath_tb.sv
module prw_datapath_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        wr_req = 0;
   logic [1:0]  wr_mode = 0;
   logic [7:0]  cpu_data = 0;
   logic [31:0] latch_data = 0;
   logic [3:0]  fill_color = 0, fill_en = 0;
   logic [2:0]  rot_cnt = 0;
   logic [1:0]  op_sel = 0;
   logic [7:0]  pix_mask = 0;
   logic [31:0] plane_out;
   logic        wr_stb;
   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   prw_datapath u_dut (.*);

   function automatic logic [7:0] rotr(logic [7:0] d, int n);
      logic [7:0] r = d;
      for (int k = 0; k < n; k++) r = {r[0], r[7:1]};
      return r;
   endfunction

   function automatic logic [31:0] model();
      logic [31:0] o;
      logic [7:0] rd = rotr(cpu_data, rot_cnt);
      logic [7:0] m = (wr_mode == 3) ? (rd & pix_mask) : pix_mask;
      for (int p = 0; p < 4; p++) begin
         logic [7:0] l = latch_data[p*8 +: 8];
         logic [7:0] s, f;
         case (wr_mode)
            0: s = fill_en[p] ? {8{fill_color[p]}} : rd;
            2: s = {8{cpu_data[p]}};
            default: s = {8{fill_color[p]}};
         endcase
         case (op_sel)
            0: f = s; 1: f = s & l; 2: f = s | l; default: f = s ^ l;
         endcase
         o[p*8 +: 8] = (wr_mode == 1) ? l : ((f & m) | (l & ~m));
      end
      return o;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic do_write(string req);
      logic [31:0] e = model();
      @(negedge clk); wr_req = 1;
      @(negedge clk); wr_req = 0;
      check({req, " strobe"}, {31'd0, wr_stb}, 32'd1);
      check(req, plane_out, e);
   endtask

   task automatic t_reset();
      check("R1", plane_out, 0);
      check("R1 strobe", {31'd0, wr_stb}, 0);
   endtask

   task automatic t_rotate();
      latch_data = 32'h0F3C_A55A; wr_mode = 0; fill_en = 0; op_sel = 0; pix_mask = 8'hFF;
      cpu_data = 8'b1000_0110;
      rot_cnt = 0; do_write("R3 cnt0");
      check("R3 value0", plane_out, {4{8'h86}});
      rot_cnt = 1; do_write("R3 cnt1");
      check("R3 value1", plane_out, {4{8'h43}});
      rot_cnt = 7; do_write("R3 cnt7");
      check("R3 value7", plane_out, {4{8'h0D}});
   endtask

   task automatic t_ops();
      latch_data = 32'h0F3C_A55A; wr_mode = 0; fill_en = 0; rot_cnt = 3; cpu_data = 8'h5C;
      pix_mask = 8'hFF;
      for (int o = 0; o < 4; o++) begin op_sel = o[1:0]; do_write("R4"); end
      check("R4 xor", plane_out, {4{8'h8B}} ^ 32'h0F3C_A55A);
   endtask

   task automatic t_mask();
      op_sel = 2; pix_mask = 8'hA5; do_write("R5 mixed");
      pix_mask = 8'h00; op_sel = 3; do_write("R5 zero");
      check("R5 latch kept", plane_out, latch_data);
   endtask

   task automatic t_mode0();
      wr_mode = 0; fill_color = 4'b1010; fill_en = 4'b0110; op_sel = 0; pix_mask = 8'hFF;
      rot_cnt = 0; cpu_data = 8'h3C; do_write("R6");
      check("R6 planes", plane_out, {8'h3C, 8'h00, 8'hFF, 8'h3C});
   endtask

   task automatic t_mode1();
      wr_mode = 1; op_sel = 3; pix_mask = 8'hFF; fill_en = 4'hF; cpu_data = 8'hFF;
      latch_data = 32'h1234_5678; do_write("R7");
      check("R7 copy", plane_out, 32'h1234_5678);
   endtask

   task automatic t_mode2();
      wr_mode = 2; fill_en = 4'hF; fill_color = 4'b0000; cpu_data = 8'hF5; op_sel = 0;
      pix_mask = 8'hFF; latch_data = 32'h0F3C_A55A; do_write("R8");
      check("R8 planes", plane_out, {8'h00, 8'hFF, 8'h00, 8'hFF});
      op_sel = 2; pix_mask = 8'h0F; do_write("R8 op+mask");
   endtask

   task automatic t_mode3();
      wr_mode = 3; fill_en = 4'h0; fill_color = 4'b1001; op_sel = 0; rot_cnt = 4;
      cpu_data = 8'h0F; pix_mask = 8'h3C; latch_data = 32'h0000_0000; do_write("R9");
      check("R9 planes", plane_out, {8'h30, 8'h00, 8'h00, 8'h30});
      op_sel = 3; latch_data = 32'hFFFF_0000; rot_cnt = 0; pix_mask = 8'hFF; do_write("R9 xor");
   endtask

   task automatic t_hold();
      logic [31:0] prev = plane_out;
      cpu_data = 8'h00; latch_data = 32'hDEAD_BEEF; wr_mode = 0;
      repeat (3) @(negedge clk);
      check("R2 hold", plane_out, prev);
      check("R2 no strobe", {31'd0, wr_stb}, 0);
   endtask

   initial begin
      fork
         begin
            #(8 * 100000);
            n_chk++; n_bad++;
            $display("FAIL watchdog act=timeout exp=done");
         end
         begin
            repeat (2) @(negedge clk);
            t_reset();
            rst_n = 1;
            @(negedge clk);
            t_rotate(); t_ops(); t_mask(); t_mode0(); t_mode1();
            t_mode2(); t_mode3(); t_hold();
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule